// File: doc/BRIEF.md
# Base-Bound Address Translator

This block sits between the processor's address generation and the memory system. Each request carries a 32-bit logical byte address. The block turns it into a 32-bit physical address, using the processor's current privilege state. When the status word's mode bit is 0 (user), the block adds a relocation base to the logical address and checks the logical address against a limit register. When the mode bit is 1 (system), the address passes through untouched. Every issued physical address is also tagged as either ordinary memory or the device register window, which is the top sixteenth of the physical space.

An access that fails the limit check is never issued. Instead, the block raises a one-cycle fault pulse that carries the interrupt parameter for a program error. The base and limit registers are loaded through a small write port. Only system mode may load them. A load attempted from user mode is discarded and reported as an illegal-instruction fault. Each result is registered, so it appears one clock after its request.

Top module: `xlate_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid and faultValid are 0. Both the base and the limit register reset to 0.
- R2: When sysMode is 1, a request with reqValid=1 produces outValid=1 on the next clock, with physAddr equal to reqAddr unchanged and no fault.
- R3: When sysMode is 0 and reqAddr does not exceed the limit, the next clock gives outValid=1 and physAddr = reqAddr + base, truncated to 32 bits (wraps modulo 2^32).
- R4: When sysMode is 0 and reqAddr is greater than the limit (unsigned), the next clock gives outValid=0, faultValid=1 and faultCode=2. An address exactly equal to the limit is accepted.
- R5: When outValid=1, ioSel is 1 if physAddr[31:28] is 4'hF (0xF0000000 to 0xFFFFFFFF) and 0 otherwise (0x00000000 to 0xEFFFFFFF).
- R6: A write with cfgWrite=1 and sysMode=1 loads cfgData into the base register when cfgSel=0, or into the limit register when cfgSel=1. A request in the same cycle still uses the old values; the new value applies from the next cycle on.
- R7: A write with cfgWrite=1 and sysMode=0 leaves both registers unchanged. On the next clock it gives faultValid=1 and faultCode=1. Any request in that same cycle is dropped (outValid=0), and code 1 takes priority over code 2.
- R8: faultValid is high only in the cycle after a faulting request or write. In a cycle after one with neither reqValid nor cfgWrite, outValid and faultValid are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysMode | input | 1 | Status word bit 0: 1 system, 0 user |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 32 | Logical byte address |
| cfgWrite | input | 1 | Register load strobe |
| cfgSel | input | 1 | 0 selects base, 1 selects limit |
| cfgData | input | 32 | Value to load |
| outValid | output | 1 | Physical address is issued |
| physAddr | output | 32 | Translated physical address |
| ioSel | output | 1 | 1 for the device register window, 0 for memory |
| faultValid | output | 1 | One-cycle fault pulse |
| faultCode | output | 2 | 1 illegal write in user mode, 2 beyond limit |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 4-bit device-window prefix. With these values the exact split between 0xEFFFFFFF and 0xF0000000 can be tested, as can an addition that wraps past 2^32. They also allow a limit equal to all ones, so that no user address can fault. Limit equality, the same-cycle load ordering, and the priority of the illegal-write fault over the limit fault are driven directly.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int FAULT_W = 2;
  typedef logic [FAULT_W-1:0] faultCode_t;
  localparam faultCode_t FC_NONE    = 2'd0;
  localparam faultCode_t FC_ILLEGAL = 2'd1;
  localparam faultCode_t FC_BOUND   = 2'd2;

  typedef struct packed {
    logic issue;    // register a translated address this cycle
    logic mapOn;    // apply base relocation
    logic wrBase;   // load base register
    logic wrBound;  // load limit register
  } xlStrobe_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sysMode,
  input  logic       reqValid,
  input  logic       cfgWrite,
  input  logic       cfgSel,
  input  logic       overBound,
  output xlStrobe_t  strobe,
  output logic       faultValid,
  output faultCode_t faultCode
);
  logic       illegalWr;
  logic       boundHit;
  faultCode_t codeNext;

  always_comb begin
    illegalWr      = cfgWrite && !sysMode;
    boundHit       = reqValid && !sysMode && overBound;
    strobe.mapOn   = !sysMode;
    strobe.issue   = reqValid && !illegalWr && !boundHit;
    strobe.wrBase  = cfgWrite && sysMode && !cfgSel;
    strobe.wrBound = cfgWrite && sysMode && cfgSel;
    if (illegalWr)     codeNext = FC_ILLEGAL;
    else if (boundHit) codeNext = FC_BOUND;
    else               codeNext = FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultValid <= 1'b0;
      faultCode  <= FC_NONE;
    end else begin
      faultValid <= illegalWr || boundHit;
      faultCode  <= codeNext;
    end
  end
endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_TOP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              overBound,
  output logic              outValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic              ioSel
);
  localparam int IO_LSB = ADDR_W - IO_TOP_W;

  logic [ADDR_W-1:0] baseQ, boundQ, physNext;

  always_comb begin
    overBound = reqAddr > boundQ;
    physNext  = strobe.mapOn ? reqAddr + baseQ : reqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      boundQ <= '0;
    end else begin
      if (strobe.wrBase)  baseQ  <= cfgData;
      if (strobe.wrBound) boundQ <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      physAddr <= '0;
      ioSel    <= 1'b0;
    end else begin
      outValid <= strobe.issue;
      if (strobe.issue) begin
        physAddr <= physNext;
        ioSel    <= &physNext[ADDR_W-1:IO_LSB];
      end
    end
  end
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_TOP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysMode,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cfgWrite,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              outValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic              ioSel,
  output logic              faultValid,
  output logic [FAULT_W-1:0] faultCode
);
  xlStrobe_t strobe;
  logic      overBound;

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sysMode(sysMode), .reqValid(reqValid),
    .cfgWrite(cfgWrite), .cfgSel(cfgSel), .overBound(overBound),
    .strobe(strobe), .faultValid(faultValid), .faultCode(faultCode)
  );

  xlate_dpath #(.ADDR_W(ADDR_W), .IO_TOP_W(IO_TOP_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .cfgData(cfgData), .overBound(overBound), .outValid(outValid),
    .physAddr(physAddr), .ioSel(ioSel)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int ADDR_W   = 32,
  parameter int IO_TOP_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sysMode,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              cfgWrite,
  input logic              outValid,
  input logic [ADDR_W-1:0] physAddr,
  input logic              ioSel,
  input logic              faultValid,
  input logic [1:0]        faultCode
);
  AST_SYS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sysMode) |=> (outValid && !faultValid && physAddr == $past(reqAddr))); // R2
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (!outValid && (faultCode == 2'd1 || faultCode == 2'd2))); // R4
  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (ioSel == (&physAddr[ADDR_W-1 -: IO_TOP_W]))); // R5
  AST_USER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !sysMode) |=> (faultValid && faultCode == 2'd1 && !outValid)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !cfgWrite) |=> (!outValid && !faultValid)); // R8
endmodule

bind xlate_unit xlate_chk #(.ADDR_W(ADDR_W), .IO_TOP_W(IO_TOP_W)) u_chk (
  .clk(clk), .rstN(rstN), .sysMode(sysMode), .reqValid(reqValid),
  .reqAddr(reqAddr), .cfgWrite(cfgWrite), .outValid(outValid),
  .physAddr(physAddr), .ioSel(ioSel), .faultValid(faultValid),
  .faultCode(faultCode)
);

// File: tb/sim_xlate_unit.sv
module sim_xlate_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sysMode = 1'b1, reqValid = 1'b0, cfgWrite = 1'b0, cfgSel = 1'b0;
  logic [31:0] reqAddr = '0, cfgData = '0;
  logic        outValid, ioSel, faultValid;
  logic [31:0] physAddr;
  logic [1:0]  faultCode;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  xlate_unit u0 (
    .clk(clk), .rstN(rstN), .sysMode(sysMode), .reqValid(reqValid),
    .reqAddr(reqAddr), .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgData(cfgData),
    .outValid(outValid), .physAddr(physAddr), .ioSel(ioSel),
    .faultValid(faultValid), .faultCode(faultCode)
  );

  // {sys, addr, expValid, expPhys, expIo, expFault, expCode}; base=0x20000000, limit=0x0FFFFFFF
  typedef struct packed {
    logic sys; logic [31:0] addr; logic v; logic [31:0] phys; logic io; logic f; logic [1:0] code;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b1, 32'h0000_1234, 1'b1, 32'h0000_1234, 1'b0, 1'b0, 2'd0},  // R2
    '{1'b1, 32'hF000_0008, 1'b1, 32'hF000_0008, 1'b1, 1'b0, 2'd0},  // R5
    '{1'b1, 32'hEFFF_FFFF, 1'b1, 32'hEFFF_FFFF, 1'b0, 1'b0, 2'd0},  // R5
    '{1'b1, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'd0},  // R2
    '{1'b0, 32'h0000_0000, 1'b1, 32'h2000_0000, 1'b0, 1'b0, 2'd0},  // R3
    '{1'b0, 32'h0FFF_FFFF, 1'b1, 32'h2FFF_FFFF, 1'b0, 1'b0, 2'd0},  // R4 equal
    '{1'b0, 32'h1000_0000, 1'b0, 32'h0,         1'b0, 1'b1, 2'd2},  // R4 over
    '{1'b0, 32'h0000_0040, 1'b1, 32'h2000_0040, 1'b0, 1'b0, 2'd0}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle, returns at next negedge with results visible.
  task automatic cycle(input logic s, input logic rv, input logic [31:0] a,
                       input logic w, input logic sel, input logic [31:0] d);
    sysMode = s; reqValid = rv; reqAddr = a; cfgWrite = w; cfgSel = sel; cfgData = d;
    @(negedge clk);
    reqValid = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic checkOut(input string req, input logic v, input logic [31:0] p,
                          input logic io, input logic f, input logic [1:0] c);
    check(req, {31'd0, outValid}, {31'd0, v});
    if (v) begin
      check(req, physAddr, p);
      check(req, {31'd0, ioSel}, {31'd0, io});
    end
    check(req, {31'd0, faultValid}, {31'd0, f});
    if (f) check(req, {30'd0, faultCode}, {30'd0, c});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outValid", {31'd0, outValid}, 32'd0);
    check("R1 reset faultValid", {31'd0, faultValid}, 32'd0);
    rstN = 1'b1;
    // R1: limit resets to 0, base to 0: user address 0 passes, address 1 faults
    cycle(1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 32'h0);
    checkOut("R1", 1'b1, 32'h0, 1'b0, 1'b0, 2'd0);
    cycle(1'b0, 1'b1, 32'h1, 1'b0, 1'b0, 32'h0);
    checkOut("R1", 1'b0, 32'h0, 1'b0, 1'b1, 2'd2);
    // R6 load base and limit
    cycle(1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 32'h2000_0000);
    cycle(1'b1, 1'b0, 32'h0, 1'b1, 1'b1, 32'h0FFF_FFFF);
    checkOut("R8 idle after write", 1'b0, 32'h0, 1'b0, 1'b0, 2'd0);
    foreach (VECS[i]) begin
      cycle(VECS[i].sys, 1'b1, VECS[i].addr, 1'b0, 1'b0, 32'h0);
      checkOut("R2/R3/R4/R5 table", VECS[i].v, VECS[i].phys, VECS[i].io, VECS[i].f, VECS[i].code);
    end
    // R8: fault is one cycle only; idle cycle quiet
    cycle(1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    checkOut("R8 idle", 1'b0, 32'h0, 1'b0, 1'b0, 2'd0);
    // R3 wrap and R5 window via relocation
    cycle(1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 32'hF000_0000);
    cycle(1'b1, 1'b0, 32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cycle(1'b0, 1'b1, 32'h0000_0004, 1'b0, 1'b0, 32'h0);
    checkOut("R5 relocated io", 1'b1, 32'hF000_0004, 1'b1, 1'b0, 2'd0);
    cycle(1'b0, 1'b1, 32'h2000_0000, 1'b0, 1'b0, 32'h0);
    checkOut("R3 wrap", 1'b1, 32'h1000_0000, 1'b0, 1'b0, 2'd0);
    cycle(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0);
    checkOut("R4 all-ones limit", 1'b1, 32'hEFFF_FFFF, 1'b0, 1'b0, 2'd0);
    // R6 same-cycle load uses old base, next cycle the new one
    cycle(1'b1, 1'b1, 32'h0000_0005, 1'b1, 1'b0, 32'h0000_0100);
    checkOut("R6 same-cycle sys", 1'b1, 32'h0000_0005, 1'b0, 1'b0, 2'd0);
    cycle(1'b0, 1'b1, 32'h0000_0005, 1'b0, 1'b0, 32'h0);
    checkOut("R6 new base", 1'b1, 32'h0000_0105, 1'b0, 1'b0, 2'd0);
    // R7 user write ignored, request dropped, code 1
    cycle(1'b0, 1'b1, 32'h0000_0007, 1'b1, 1'b0, 32'h0800_0000);
    checkOut("R7 user write", 1'b0, 32'h0, 1'b0, 1'b1, 2'd1);
    cycle(1'b0, 1'b1, 32'h0000_0007, 1'b0, 1'b0, 32'h0);
    checkOut("R7 base unchanged", 1'b1, 32'h0000_0107, 1'b0, 1'b0, 2'd0);
    cycle(1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_0000);
    checkOut("R7 limit write", 1'b0, 32'h0, 1'b0, 1'b1, 2'd1);
    cycle(1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 32'h0);
    checkOut("R7 limit unchanged", 1'b1, 32'h8000_0100, 1'b0, 1'b0, 2'd0);
    // R7 priority over bound fault: shrink limit, then fault both ways
    cycle(1'b1, 1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_00FF);
    cycle(1'b0, 1'b1, 32'h0000_1000, 1'b1, 1'b0, 32'h0);
    checkOut("R7 priority", 1'b0, 32'h0, 1'b0, 1'b1, 2'd1);
    cycle(1'b0, 1'b1, 32'h0000_1000, 1'b0, 1'b0, 32'h0);
    checkOut("R4 after shrink", 1'b0, 32'h0, 1'b0, 1'b1, 2'd2);
    cycle(1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    checkOut("R8 pulse ends", 1'b0, 32'h0, 1'b0, 1'b0, 2'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule